// File: doc/BRIEF.md
# Field-Assisted Row Write Sequencer

This block runs the write of one full row in a magnetic-cell memory subarray. In this subarray a single assist current runs the length of the row and is shared by every cell on it. A request carries a row address and a complete row of data, and the sequencer drives the subarray through the write in a fixed order. It selects the row and turns on the assist drive first, so the cells are already unsettled when the column drivers start. It then drives every column for a programmed pulse, with the drive direction giving each bit's value. After the pulse it releases all drives and reads the row back.

When the read-back differs from the intended row in any bit, the whole row is written again. Per-attempt success is only about nine in ten, so retries are routine rather than exceptional. Once the configured number of attempts has failed, the block reports an error and returns to idle. New requests are taken only while idle.

Top module: `frow_write_seq`

## Requirements
- R1: After reset and whenever idle, the wordline, assist, column enables, column directions, read enable, busy, done and error outputs are all low.
- R2: A request seen while idle is accepted at that clock edge. From the next cycle, the wordline and assist are both high for LEAD_CYC cycles before any column enable rises, and both stay high throughout the column pulse.
- R3: During the write pulse, all ROW_W column enables are high together for exactly PULSE_CYC cycles, with no column masked.
- R4: During the pulse, column direction bit i equals data bit i. A 1 means reverse drive and writes a 1; a 0 means forward drive and writes a 0. The directions stay steady for the whole pulse.
- R5: The cycle after the pulse has every drive low, including the wordline. The cycle after that is a verify read, with the wordline and read enable high and the assist and columns off.
- R6: The read data returned on the cycle after the verify read is compared in full with the latched row. If it matches, done is high for exactly one cycle, and the block is idle on the following cycle.
- R7: On a mismatch with attempts remaining, a new attempt begins on the next cycle with the assist phase (R2) and rewrites the whole row.
- R8: If MAX_TRY attempts all mismatch, error is high for one cycle instead of done, no further write is issued, and the block returns to idle.
- R9: Requests that arrive while busy are ignored. The row address and data in use do not change, and the other row is not written.
- R10: Busy is high from the cycle after acceptance through the done or error cycle, and low on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request, taken only when idle |
| req_addr | input | ADDR_W | Row to write |
| req_data | input | ROW_W | Row contents to write |
| rd_data | input | ROW_W | Row read from the array, valid the cycle after rd_en |
| wl_on | output | 1 | Wordline of the selected row |
| row_addr | output | ADDR_W | Selected row address |
| assist_on | output | 1 | Row-wide assist current enable |
| col_drv_en | output | ROW_W | Per-column write drive enable |
| col_drv_rev | output | ROW_W | Per-column direction, 1 = reverse (writes 1) |
| rd_en | output | 1 | Verify read strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: row verified |
| err | output | 1 | One-cycle pulse: attempts exhausted |

## Verification
The bench pushes the retry loop to both ends. One case passes at once, others fail one or two attempts on bits at the row edges (bit 0, bit 127) and the middle, and one fails every attempt. A wrong retry count or a wrong last-attempt test shows up as an extra or missing write pulse, or as done where error was due. All-ones and all-zeros rows expose a swapped or partly stuck direction bus, because the bench array stores what the direction lines carried. A request held high during a busy operation exposes a design that re-latches its inputs mid-write: the row address would move, and the neighbouring row would be written.

// File: rtl/frow_pkg.sv
// Shared type for the field-assisted row write sequencer.
package frow_pkg;
    typedef enum logic [2:0] {
        S_IDLE,     // waiting for a request
        S_ASSIST,   // wordline + assist, columns quiet
        S_WRITE,    // assist + all columns driven
        S_SETTLE,   // everything released
        S_VERIFY,   // read strobe with wordline
        S_COMPARE,  // read data checked
        S_DONE,     // success pulse
        S_ERROR     // failure pulse
    } seq_state_t;
endpackage

// File: rtl/frow_phase_timer.sv
// Down-counter that times the assist lead and the write pulse.
// Assumes load values fit in CNT_W bits; expired is high while count is zero.
module frow_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/frow_row_cmp.sv
// Full-row comparator for the verify read, split into groups so the
// reduction tree is balanced. Assumes ROW_W is a multiple of GRP_W.
module frow_row_cmp #(
    parameter int ROW_W = 128,
    parameter int GRP_W = 32
) (
    input  logic [ROW_W-1:0] expect_row,
    input  logic [ROW_W-1:0] seen_row,
    output logic             mismatch
);
    localparam int NGRP = ROW_W / GRP_W;

    logic [NGRP-1:0] grp_diff;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // Per-group difference flag.
        assign grp_diff[g] = |(expect_row[g*GRP_W +: GRP_W] ^ seen_row[g*GRP_W +: GRP_W]);
    end

    assign mismatch = |grp_diff;
endmodule

// File: rtl/frow_write_seq.sv
// Field-assisted row write sequencer. Selects a row, raises the shared
// assist current LEAD_CYC cycles ahead of the column drivers, drives every
// column for PULSE_CYC cycles, releases, reads back and retries up to
// MAX_TRY attempts. Assumes rd_data is valid the cycle after rd_en.
module frow_write_seq #(
    parameter int ROW_W     = 128,
    parameter int ADDR_W    = 4,
    parameter int LEAD_CYC  = 2,
    parameter int PULSE_CYC = 3,
    parameter int MAX_TRY   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ROW_W-1:0]  req_data,
    input  logic [ROW_W-1:0]  rd_data,
    output logic              wl_on,
    output logic [ADDR_W-1:0] row_addr,
    output logic              assist_on,
    output logic [ROW_W-1:0]  col_drv_en,
    output logic [ROW_W-1:0]  col_drv_rev,
    output logic              rd_en,
    output logic              busy,
    output logic              done,
    output logic              err
);
    import frow_pkg::*;

    localparam int MAXPH = (LEAD_CYC > PULSE_CYC) ? LEAD_CYC : PULSE_CYC;
    localparam int CNT_W = $clog2(MAXPH + 1);
    localparam int TRY_W = $clog2(MAX_TRY + 1);
    localparam logic [CNT_W-1:0] LEAD_LD  = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRY - 1);

    seq_state_t        state, nxt;
    logic [ROW_W-1:0]  wr_row;
    logic [ADDR_W-1:0] wr_addr;
    logic [TRY_W-1:0]  tries;
    logic              ph_load, ph_done, row_bad;
    logic [CNT_W-1:0]  ph_val;

    frow_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .expired(ph_done)
    );

    frow_row_cmp #(.ROW_W(ROW_W), .GRP_W(32)) u_cmp (
        .expect_row(wr_row), .seen_row(rd_data), .mismatch(row_bad)
    );

    // Next-state selection for the write/verify/retry sequence.
    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:    if (req_valid) nxt = S_ASSIST;
            S_ASSIST:  if (ph_done) nxt = S_WRITE;
            S_WRITE:   if (ph_done) nxt = S_SETTLE;
            S_SETTLE:  nxt = S_VERIFY;
            S_VERIFY:  nxt = S_COMPARE;
            S_COMPARE: if (!row_bad)              nxt = S_DONE;
                       else if (tries == LAST_TRY) nxt = S_ERROR;
                       else                        nxt = S_ASSIST;
            default:   nxt = S_IDLE;
        endcase
    end

    // Timer reload on entry to a timed phase.
    assign ph_load = (nxt != state) && (nxt == S_ASSIST || nxt == S_WRITE);
    assign ph_val  = (nxt == S_ASSIST) ? LEAD_LD : PULSE_LD;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Latch the request when accepted in idle; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_row  <= '0;
            wr_addr <= '0;
        end else if (state == S_IDLE && req_valid) begin
            wr_row  <= req_data;
            wr_addr <= req_addr;
        end
    end

    // Attempt counter: cleared on accept, bumped on each failed compare.
    always_ff @(posedge clk) begin
        if (!rst_n)                            tries <= '0;
        else if (state == S_IDLE)              tries <= '0;
        else if (state == S_COMPARE && row_bad) tries <= tries + 1'b1;
    end

    // Output decode from the current state.
    assign wl_on       = (state == S_ASSIST) || (state == S_WRITE) || (state == S_VERIFY);
    assign assist_on   = (state == S_ASSIST) || (state == S_WRITE);
    assign col_drv_en  = {ROW_W{state == S_WRITE}};
    assign col_drv_rev = (state == S_WRITE) ? wr_row : '0;
    assign rd_en       = (state == S_VERIFY);
    assign row_addr    = wr_addr;
    assign busy        = (state != S_IDLE);
    assign done        = (state == S_DONE);
    assign err         = (state == S_ERROR);
endmodule

// File: rtl/frow_write_seq_chk.sv
// Protocol checker for the row write sequencer, bound to every instance.
module frow_write_seq_chk #(
    parameter int ROW_W  = 128,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ROW_W-1:0]  req_data,
    input logic [ROW_W-1:0]  rd_data,
    input logic              wl_on,
    input logic [ADDR_W-1:0] row_addr,
    input logic              assist_on,
    input logic [ROW_W-1:0]  col_drv_en,
    input logic [ROW_W-1:0]  col_drv_rev,
    input logic              rd_en,
    input logic              busy,
    input logic              done,
    input logic              err
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wl_on && !assist_on && !rd_en && col_drv_en == '0));

    p_assist_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_drv_en[0]) |-> ($past(assist_on) && $past(wl_on)));

    p_drive_under_assist_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|col_drv_en) |-> (assist_on && wl_on));

    p_full_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|col_drv_en) |-> (&col_drv_en));

    p_dir_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_drv_en[0] && $past(col_drv_en[0])) |-> $stable(col_drv_rev));

    p_read_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (wl_on && !assist_on && col_drv_en == '0));

    p_gap_before_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(assist_on) |-> !wl_on);

    p_done_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_done_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_en, 2));
endmodule

bind frow_write_seq frow_write_seq_chk #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/frow_write_seq_tb.sv
// Bench: behavioural array with per-attempt failure masks, cycle-by-cycle
// expected-output model, final row and attempt-count scoreboard.
module frow_write_seq_tb;
    localparam int ROW_W = 128, ADDR_W = 4, LEAD = 2, PULSE = 3, MAXT = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ROW_W-1:0]  req_data = '0;
    logic [ROW_W-1:0]  rd_data;
    logic              wl_on, assist_on, rd_en, busy, done, err;
    logic [ADDR_W-1:0] row_addr;
    logic [ROW_W-1:0]  col_drv_en, col_drv_rev;

    logic [ROW_W-1:0]  mem [16];
    logic [ROW_W-1:0]  fm  [MAXT];
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    frow_write_seq #(.ROW_W(ROW_W), .ADDR_W(ADDR_W), .LEAD_CYC(LEAD),
                     .PULSE_CYC(PULSE), .MAX_TRY(MAXT)) u_dut (.*);

    // Array read port: data appears the cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (rd_en && wl_on) rd_data <= mem[row_addr];
    end

    task automatic chk(input string tag, input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic look(input string tag, input bit e_wl, e_as, e_col, e_rd, e_busy, e_done, e_err);
        chk({tag, " wl"},     ROW_W'(wl_on),     ROW_W'(e_wl));
        chk({tag, " assist"}, ROW_W'(assist_on), ROW_W'(e_as));
        chk({tag, " colen"},  col_drv_en,        e_col ? '1 : '0);
        chk({tag, " rden"},   ROW_W'(rd_en),     ROW_W'(e_rd));
        chk({tag, " busy"},   ROW_W'(busy),      ROW_W'(e_busy));
        chk({tag, " done"},   ROW_W'(done),      ROW_W'(e_done));
        chk({tag, " err"},    ROW_W'(err),       ROW_W'(e_err));
    endtask

    // One complete operation; nfail leading attempts fail with masks fm[].
    task automatic run_op(input logic [ADDR_W-1:0] a, input logic [ROW_W-1:0] d,
                          input int nfail, input bit inject);
        logic [ROW_W-1:0] seen, other;
        int att;
        bit failed;
        other = mem[a + 1'b1];
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        @(negedge clk);
        if (inject) begin req_addr = a + 1'b1; req_data = ~d; end
        else req_valid = 1'b0;
        att = 0;
        failed = 1'b0;
        forever begin
            for (int i = 0; i < LEAD; i++) begin
                look("R2 lead", 1, 1, 0, 0, 1, 0, 0);
                chk("R9 addr", ROW_W'(row_addr), ROW_W'(a));
                @(negedge clk);
            end
            for (int i = 0; i < PULSE; i++) begin
                look("R3 pulse", 1, 1, 1, 0, 1, 0, 0);
                chk("R4 dir", col_drv_rev, d);
                seen = col_drv_rev;
                @(negedge clk);
            end
            mem[a] = seen ^ ((att < nfail) ? fm[att] : '0);
            req_valid = 1'b0;
            look("R5 settle", 0, 0, 0, 0, 1, 0, 0);
            @(negedge clk);
            look("R5 verify", 1, 0, 0, 1, 1, 0, 0);
            @(negedge clk);
            look("R6 compare", 0, 0, 0, 0, 1, 0, 0);
            @(negedge clk);
            if (att < nfail && att == MAXT - 1) begin failed = 1'b1; break; end
            if (att >= nfail) break;
            att++;
        end
        if (failed) look("R8 error", 0, 0, 0, 0, 1, 0, 1);
        else        look("R6 done", 0, 0, 0, 0, 1, 1, 0);
        chk("R7 attempts", ROW_W'(att + 1), ROW_W'((nfail < MAXT) ? nfail + 1 : MAXT));
        @(negedge clk);
        look("R10 idle after", 0, 0, 0, 0, 0, 0, 0);
        chk("R8 row content", mem[a], failed ? (d ^ fm[MAXT-1]) : d);
        if (inject) chk("R9 other row untouched", mem[a + 1'b1], other);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        rd_data = '0;
        repeat (3) @(negedge clk);
        look("R1 reset", 0, 0, 0, 0, 0, 0, 0);
        chk("R1 dir", col_drv_rev, '0);
        rst_n = 1'b1;
        @(negedge clk);
        look("R1 idle", 0, 0, 0, 0, 0, 0, 0);

        fm[0] = '0; fm[1] = '0; fm[2] = '0;
        run_op(4'd3, {4{32'hA5C3_0F96}}, 0, 0);             // R6 first-try pass

        fm[0] = 128'h1;
        run_op(4'd5, {4{32'h1234_5678}}, 1, 0);             // R7 one retry

        fm[0] = {1'b1, 127'h0}; fm[1] = 128'h1 << 64;
        run_op(4'd7, {4{32'hDEAD_BEEF}}, 2, 0);             // R7 two retries

        fm[0] = 128'h1; fm[1] = 128'h2; fm[2] = 128'h1 << 100;
        run_op(4'd9, {4{32'h0F0F_F0F0}}, 3, 0);             // R8 exhaust

        fm[0] = '0;
        run_op(4'd1, '1, 0, 0);                             // R4 all ones
        run_op(4'd1, '0, 0, 0);                             // R4 all zeros

        fm[0] = 128'h80;
        run_op(4'd11, {4{32'h3C3C_5A5A}}, 1, 1);            // R9 request while busy

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule